// File: doc/BRIEF.md
# Biased-Product Lag Autocorrelator

This block computes the autocorrelation of a stream of 2-bit samples over a parameterized number of time lags (32 by default). Each accepted sample is paired with itself and with each of the previous NLAGS-1 accepted samples. Every pair is turned into a non-negative weight by an offset multiplier, so a channel's running total only ever grows.

Each lag channel keeps a 4-bit residue. A carry out of the residue increments a wide counter. The counter saturates at its maximum value and sets a sticky flag when it would have wrapped.

A latch strobe copies every channel's counter, residue and flag into a holding bank. Integration goes on undisturbed while the bank is read out one lag at a time under a read enable. The read enable stands in for a slower output clock.

Top module: `lag_correlator`

## Requirements
- R1: While reset is asserted, and after it is released, all residues, counters, overflow flags, holding entries, the sample history (each entry holding code 2'b00) and the read pointer are zero. rd_lag, rd_count, rd_resid and rd_ovf therefore read 0.
- R2: A sample code carries its sign in bit 1 (1 = negative) and its magnitude in bit 0 (1 = large, weight 3; 0 = small, weight 1). The biased product of two codes is 4 plus the signed product. The large-by-large magnitude is taken as 4 instead of 9, so the result always lies in 0..8.
- R3: Lag channel k pairs the sample accepted in this cycle with the sample accepted k acceptances earlier. Channel 0 pairs the sample with itself. The history advances only on cycles with in_en high, and it is not affected by clear.
- R4: On a cycle with in_en high and clear low, each channel adds its biased product to its residue modulo 16. If that sum reaches 16, the channel's counter goes up by one. With in_en low, residues and counters hold.
- R5: A carry that arrives while a counter is at its all-ones value leaves the counter at all-ones and sets that channel's overflow flag. The flag stays set until clear.
- R6: clear zeroes every residue, counter and overflow flag on the next edge. It takes priority over accumulation, so a sample presented with clear is not accumulated.
- R7: latch copies, for every lag, the counter, residue and flag values held before that edge into the holding bank. It also sets the read pointer to lag 0. Accumulation and clear in the same cycle still act on the live channels.
- R8: rd_lag shows the read pointer. rd_count, rd_resid and rd_ovf show the holding entry of that lag in the same cycle. rd_en advances the pointer by one and wraps from NLAGS-1 to 0. latch takes priority over rd_en.
- R9: Holding entries change only on latch. Clearing and accumulating during readout do not alter the values read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero all live residues, counters and flags |
| in_en | input | 1 | Accept the sample on this cycle |
| sample | input | 2 | Sample code: bit 1 sign, bit 0 magnitude |
| latch | input | 1 | Copy live channel state into the holding bank and restart readout |
| rd_en | input | 1 | Advance the read pointer |
| rd_lag | output | $clog2(NLAGS) | Lag index being read |
| rd_count | output | CNT_W | Latched counter of that lag |
| rd_resid | output | ACC_W | Latched residue of that lag |
| rd_ovf | output | 1 | Latched overflow flag of that lag |

## Verification
Counter saturation is the hardest state to reach from the ports. At the full counter width it needs millions of carries, and each carry takes at least two samples. The bench therefore builds the block with an 8-bit counter and then drives a long run of identical large-magnitude samples. Once the history is filled, every lag adds 8 per sample and so carries every second cycle. This pushes all lags past saturation in a few hundred cycles. Clear then has to remove the sticky flags, and a latch taken in the same cycle as clear has to capture the values from before the clear.

// File: rtl/lag_correlator.sv
module lag_correlator #(
  parameter int NLAGS = 32,
  parameter int ACC_W = 4,
  parameter int CNT_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       in_en,
  input  logic [1:0]                 sample,
  input  logic                       latch,
  input  logic                       rd_en,
  output logic [$clog2(NLAGS)-1:0]   rd_lag,
  output logic [CNT_W-1:0]           rd_count,
  output logic [ACC_W-1:0]           rd_resid,
  output logic                       rd_ovf
);
  localparam int IW = $clog2(NLAGS);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [IW-1:0] LAST = IW'(NLAGS - 1);

  function automatic logic [3:0] bias_prod(input logic [1:0] a, input logic [1:0] b);
    logic [3:0] mag;
    mag = (a[0] & b[0]) ? 4'd4 : ((a[0] | b[0]) ? 4'd3 : 4'd1);
    return (a[1] ^ b[1]) ? (4'd4 - mag) : (4'd4 + mag);
  endfunction

  logic [1:0]       hist     [NLAGS-1];
  logic [1:0]       tap      [NLAGS];
  logic [ACC_W-1:0] acc      [NLAGS];
  logic [CNT_W-1:0] cnt      [NLAGS];
  logic             ovf      [NLAGS];
  logic [ACC_W-1:0] hold_acc [NLAGS];
  logic [CNT_W-1:0] hold_cnt [NLAGS];
  logic             hold_ovf [NLAGS];
  logic [IW-1:0]    rd_ptr;

  assign tap[0] = sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLAGS-1; i++) hist[i] <= 2'b00;
    end else if (in_en) begin
      hist[0] <= sample;
      for (int i = 1; i < NLAGS-1; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_ptr <= '0;
    else if (latch)  rd_ptr <= '0;
    else if (rd_en)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  end

  assign rd_lag   = rd_ptr;
  assign rd_count = hold_cnt[rd_ptr];
  assign rd_resid = hold_acc[rd_ptr];
  assign rd_ovf   = hold_ovf[rd_ptr];

  a_r8_latch_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> rd_ptr == '0);
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !latch && rd_ptr == LAST) |=> rd_ptr == '0);

  for (genvar k = 0; k < NLAGS; k++) begin : g_lag
    if (k > 0) begin : g_tap
      assign tap[k] = hist[k-1];
    end

    logic [ACC_W:0] sum;
    assign sum = {1'b0, acc[k]} + (ACC_W+1)'(bias_prod(sample, tap[k]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[k] <= '0;
        cnt[k] <= '0;
        ovf[k] <= 1'b0;
      end else if (clear) begin
        acc[k] <= '0;
        cnt[k] <= '0;
        ovf[k] <= 1'b0;
      end else if (in_en) begin
        acc[k] <= sum[ACC_W-1:0];
        if (sum[ACC_W]) begin
          if (cnt[k] == CMAX) ovf[k] <= 1'b1;
          else                cnt[k] <= cnt[k] + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_acc[k] <= '0;
        hold_cnt[k] <= '0;
        hold_ovf[k] <= 1'b0;
      end else if (latch) begin
        hold_acc[k] <= acc[k];
        hold_cnt[k] <= cnt[k];
        hold_ovf[k] <= ovf[k];
      end
    end

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[k] == CMAX && !clear) |=> cnt[k] == CMAX);
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[k] && !clear) |=> ovf[k]);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt[k] == '0 && acc[k] == '0 && !ovf[k]));
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_en && !clear) |=> ($stable(cnt[k]) && $stable(acc[k])));
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> (hold_cnt[k] == $past(cnt[k]) && hold_acc[k] == $past(acc[k])));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> ($stable(hold_cnt[k]) && $stable(hold_ovf[k])));
  end
endmodule

// File: tb/tb_lag_correlator.sv
module tb_lag_correlator;
  localparam int NL = 32;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0, in_en_i = 1'b0, latch_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] sample_i = 2'b00;
  logic [4:0] rd_lag;
  logic [CW-1:0] rd_count;
  logic [AW-1:0] rd_resid;
  logic rd_ovf;

  always #4 clk = ~clk;

  lag_correlator #(.NLAGS(NL), .ACC_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear_i), .in_en(in_en_i), .sample(sample_i),
    .latch(latch_i), .rd_en(rd_en_i), .rd_lag(rd_lag), .rd_count(rd_count),
    .rd_resid(rd_resid), .rd_ovf(rd_ovf));

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  int m_acc [NL], m_cnt [NL], m_ovf [NL];
  int h_acc [NL], h_cnt [NL], h_ovf [NL];
  int m_hist [NL];
  int m_ptr = 0;

  function automatic int weight(input int code);
    int m;
    m = (code & 1) ? 3 : 1;
    return (code & 2) ? -m : m;
  endfunction

  function automatic int biased(input int a, input int b);
    int p;
    p = weight(a) * weight(b);
    if (p == 9) p = 4;
    if (p == -9) p = -4;
    return p + 4;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NL; k++) begin
        m_acc[k] = 0; m_cnt[k] = 0; m_ovf[k] = 0;
        h_acc[k] = 0; h_cnt[k] = 0; h_ovf[k] = 0; m_hist[k] = 0;
      end
      m_ptr = 0;
    end else begin
      if (latch_i) begin
        for (int k = 0; k < NL; k++) begin
          h_acc[k] = m_acc[k]; h_cnt[k] = m_cnt[k]; h_ovf[k] = m_ovf[k];
        end
        m_ptr = 0;
      end else if (rd_en_i) m_ptr = (m_ptr + 1) % NL;
      for (int k = 0; k < NL; k++) begin
        if (clear_i) begin
          m_acc[k] = 0; m_cnt[k] = 0; m_ovf[k] = 0;
        end else if (in_en_i) begin
          int s;
          s = m_acc[k] + biased(int'(sample_i), (k == 0) ? int'(sample_i) : m_hist[k-1]);
          m_acc[k] = s % 16;
          if (s >= 16) begin
            if (m_cnt[k] == CMAX) m_ovf[k] = 1;
            else m_cnt[k] = m_cnt[k] + 1;
          end
        end
      end
      if (in_en_i) begin
        for (int j = NL-1; j > 0; j--) m_hist[j] = m_hist[j-1];
        m_hist[0] = int'(sample_i);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(phase, "rd_lag", int'(rd_lag), m_ptr);
      check(phase, "rd_count", int'(rd_count), h_cnt[m_ptr]);
      check(phase, "rd_resid", int'(rd_resid), h_acc[m_ptr]);
      check(phase, "rd_ovf", int'(rd_ovf), h_ovf[m_ptr]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drive(input bit c, input bit e, input logic [1:0] s, input bit l, input bit r);
    clear_i = c; in_en_i = e; sample_i = s; latch_i = l; rd_en_i = r;
    @(negedge clk);
  endtask

  task automatic readout();
    drive(0, 0, 2'b00, 1, 0);
    for (int i = 0; i < NL; i++) drive(0, 0, 2'b00, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rd_count after reset", int'(rd_count), 0);
    check("R1", "rd_lag after reset", int'(rd_lag), 0);
    readout();

    phase = "R2";
    for (int i = 0; i < 48; i++) drive(0, 1, 2'(i % 4), 0, 0);
    readout();

    phase = "R3";
    drive(1, 0, 2'b00, 0, 0);
    for (int i = 0; i < 40; i++) drive(0, 1, 2'((i * 7 + i / 3) % 4), 0, 0);
    readout();

    phase = "R4";
    drive(1, 0, 2'b00, 0, 0);
    for (int i = 0; i < 400; i++) drive(0, 1'($urandom % 3 != 0), 2'($urandom), 0, 0);
    drive(0, 0, 2'b00, 1, 0);
    for (int i = 0; i < NL; i++) drive(0, 0, 2'($urandom), 0, 1'($urandom % 2));
    readout();

    phase = "R9";
    drive(0, 0, 2'b00, 1, 0);
    for (int i = 0; i < NL; i++) drive(1'(i == 5), 1, 2'($urandom), 0, 1);

    phase = "R5";
    drive(1, 0, 2'b00, 0, 0);
    for (int i = 0; i < 700; i++) drive(0, 1, 2'b11, 0, 0);
    readout();

    phase = "R7";
    drive(1, 1, 2'b11, 1, 0);
    for (int i = 0; i < NL; i++) drive(0, 1, 2'b01, 0, 1);

    phase = "R6";
    readout();

    phase = "R8";
    for (int i = 0; i < 5; i++) drive(0, 0, 2'b00, 0, 1);
    drive(0, 0, 2'b00, 1, 1);
    check("R8", "rd_lag after latch with rd_en", int'(rd_lag), 0);
    for (int i = 0; i < NL + 3; i++) drive(0, 1, 2'($urandom), 0, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule